// File: doc/BRIEF.md
# Transceiver Direction and Enable Sequencer

This block controls the direction pin and the active-low output-enable pin of an external bidirectional level-translating bus buffer. User logic asks for a direction through a valid/ready handshake. When the requested direction is new, the block turns the buffer outputs off and waits out the turn-off time. It then flips the direction pin and waits out the turn-off time again, plus a safety margin. Next it turns the outputs back on and waits for the newly driving side to become active. Only after that does it raise a transfer-ready flag. At no point can both sides of the buffer drive at once.

Every wait is a parameter given in clock cycles. The user derives each value from the worst-case nanosecond figures for the supply pairing in use, rounded up. Timing grows much longer at low supply voltages, so none of the waits is fixed. A build option picks the turn-off wait. By default it is the longer of the two sides' turn-off times. The other choice is the turn-off time of the side that is actually being switched off.

Top module: `xcvr_dir_sequencer`

## Requirements
- R1: While reset is asserted, `xcvr_oe_n` is 1 (outputs off), `xcvr_dir` equals `DIR_RESET`, and both `req_ready` and `xfer_ready` are 0.
- R2: After reset is released, the block runs one enable sequence without changing `xcvr_dir`. `xcvr_oe_n` falls after the settle time (turn-off wait of the default direction plus `HEADROOM_CYC`), counted in rising edges from the first edge with reset high. `xfer_ready` rises only after the enable wait of R7.
- R3: Direction encoding: 1 means side A drives side B (side B outputs active), and 0 means side B drives side A (side A outputs active). After an accepted request completes, `xcvr_dir` equals the requested `req_dir`.
- R4: `xcvr_dir` changes only in a cycle where `xcvr_oe_n` is 1 both before and after the change.
- R5: When a request for the other direction is accepted, `xcvr_oe_n` rises on that same edge. `xcvr_dir` changes exactly turn-off wait + 1 edges later. With the default option, the turn-off wait is max(`DIS_A_CYC`, `DIS_B_CYC`).
- R6: `xcvr_oe_n` falls exactly turn-off wait + `HEADROOM_CYC` edges after `xcvr_dir` changes.
- R7: `xfer_ready` rises exactly the enable wait of the newly driving side after `xcvr_oe_n` falls: `EN_B_CYC` when `xcvr_dir` is 1 and `EN_A_CYC` when it is 0. While `xfer_ready` is 1, `xcvr_oe_n` is 0.
- R8: A request for the direction already in use is accepted while `req_ready` is 1. It causes no pin activity: `xcvr_dir` and `xcvr_oe_n` stay the same, and `req_ready` and `xfer_ready` stay 1.
- R9: `req_ready` drops on the edge after a direction-changing request is accepted and stays 0 until `xfer_ready` returns. A request presented meanwhile is held by the handshake and is carried out afterwards.
- R10: With `PER_SIDE_DIS` = 1, the turn-off wait in R5, R6 and R2 is the time of the side being switched off: `DIS_B_CYC` when leaving direction 1, and `DIS_A_CYC` when leaving direction 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Direction request present |
| req_dir | input | 1 | Requested direction (1 = A drives B) |
| req_ready | output | 1 | Request taken on this edge when high together with req_valid |
| xcvr_dir | output | 1 | Direction pin to the buffer |
| xcvr_oe_n | output | 1 | Active-low output-enable pin to the buffer |
| xfer_ready | output | 1 | Buffer enabled and settled; data may move |

## Verification
The hardest case to reach from the ports is a request that arrives while a switch is still in progress. It must be held off and must not be lost. The stimulus reaches it by placing a second request, for the original direction, on the cycle right after a switch is accepted. It then keeps that request valid until the handshake takes it, and confirms that the pins go back to the original direction. A second instance, built with the per-side turn-off option and a different reset direction, runs the same sweeps. On every switch, gap monitors compare each measured pin-to-pin interval with the value computed from the parameters.

// File: rtl/xds_pkg.sv
package xds_pkg;

   typedef enum logic [2:0] {
      ST_DISABLING  = 3'd0,
      ST_DIR_SWITCH = 3'd1,
      ST_DIR_SETTLE = 3'd2,
      ST_ENABLING   = 3'd3,
      ST_READY      = 3'd4
   } xds_state_e;

endpackage

// File: rtl/xds_delay_sel.sv
module xds_delay_sel #(
   parameter int W          = 4,
   parameter int DIS_A_CYC  = 3,
   parameter int DIS_B_CYC  = 5,
   parameter int EN_A_CYC   = 4,
   parameter int EN_B_CYC   = 2,
   parameter bit PER_SIDE   = 1'b0
) (
   input  logic         off_side,
   input  logic         drive_side,
   output logic [W-1:0] dis_cyc,
   output logic [W-1:0] en_cyc
);
   localparam int DIS_MAX = (DIS_A_CYC > DIS_B_CYC) ? DIS_A_CYC : DIS_B_CYC;

   // direction 1 turns on side B outputs, direction 0 turns on side A
   assign en_cyc = drive_side ? W'(EN_B_CYC) : W'(EN_A_CYC);

   generate
      if (PER_SIDE) begin : g_per_side
         assign dis_cyc = off_side ? W'(DIS_B_CYC) : W'(DIS_A_CYC);
      end else begin : g_worst
         logic unused_side;
         assign unused_side = off_side;
         assign dis_cyc = W'(DIS_MAX);
      end
   endgenerate
endmodule

// File: rtl/xds_timer.sv
module xds_timer #(
   parameter int           W       = 4,
   parameter logic [W-1:0] RST_VAL = '0
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         load,
   input  logic [W-1:0] load_val,
   output logic         zero
);
   logic [W-1:0] cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)            cnt <= RST_VAL;
      else if (load)         cnt <= load_val;
      else if (cnt != '0)    cnt <= cnt - W'(1);
   end

   assign zero = (cnt == '0);
endmodule

// File: rtl/xds_ctrl.sv
module xds_ctrl
   import xds_pkg::*;
#(
   parameter int W            = 4,
   parameter int HEADROOM_CYC = 2,
   parameter bit DIR_RESET    = 1'b1
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         req_valid,
   input  logic         req_dir,
   input  logic         t_zero,
   input  logic [W-1:0] dis_cyc,
   input  logic [W-1:0] en_cyc,
   output logic         t_load,
   output logic [W-1:0] t_val,
   output logic         sel_off,
   output logic         xcvr_dir,
   output logic         xcvr_oe_n,
   output logic         req_ready,
   output logic         xfer_ready
);
   xds_state_e state;
   logic       off_side;
   logic       take_switch;

   assign req_ready   = (state == ST_READY);
   assign xfer_ready  = (state == ST_READY);
   assign take_switch = req_ready && req_valid && (req_dir != xcvr_dir);
   assign sel_off     = (state == ST_READY) ? xcvr_dir : off_side;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state     <= ST_DIR_SETTLE;
         xcvr_dir  <= DIR_RESET;
         xcvr_oe_n <= 1'b1;
         off_side  <= DIR_RESET;
      end else begin
         unique case (state)
            ST_READY: if (take_switch) begin
               xcvr_oe_n <= 1'b1;
               off_side  <= xcvr_dir;
               state     <= ST_DISABLING;
            end
            ST_DISABLING:  if (t_zero) state <= ST_DIR_SWITCH;
            ST_DIR_SWITCH: begin
               xcvr_dir <= ~xcvr_dir;
               state    <= ST_DIR_SETTLE;
            end
            ST_DIR_SETTLE: if (t_zero) begin
               xcvr_oe_n <= 1'b0;
               state     <= ST_ENABLING;
            end
            ST_ENABLING:   if (t_zero) state <= ST_READY;
            default:       state <= ST_DISABLING;
         endcase
      end
   end

   always_comb begin
      t_load = 1'b0;
      t_val  = '0;
      unique case (state)
         ST_READY: if (take_switch) begin
            t_load = 1'b1;
            t_val  = dis_cyc - W'(1);
         end
         ST_DIR_SWITCH: begin
            t_load = 1'b1;
            t_val  = dis_cyc + W'(HEADROOM_CYC) - W'(1);
         end
         ST_DIR_SETTLE: if (t_zero) begin
            t_load = 1'b1;
            t_val  = en_cyc - W'(1);
         end
         default: ;
      endcase
   end
endmodule

// File: rtl/xcvr_dir_sequencer.sv
module xcvr_dir_sequencer #(
   parameter int DIS_A_CYC    = 3,
   parameter int DIS_B_CYC    = 5,
   parameter int EN_A_CYC     = 4,
   parameter int EN_B_CYC     = 2,
   parameter int HEADROOM_CYC = 2,
   parameter bit DIR_RESET    = 1'b1,
   parameter bit PER_SIDE_DIS = 1'b0
) (
   input  logic clk,
   input  logic rst_n,
   input  logic req_valid,
   input  logic req_dir,
   output logic req_ready,
   output logic xcvr_dir,
   output logic xcvr_oe_n,
   output logic xfer_ready
);
   localparam int DIS_MAX = (DIS_A_CYC > DIS_B_CYC) ? DIS_A_CYC : DIS_B_CYC;
   localparam int EN_MAX  = (EN_A_CYC > EN_B_CYC) ? EN_A_CYC : EN_B_CYC;
   localparam int CNT_W   = $clog2(DIS_MAX + HEADROOM_CYC + EN_MAX + 2);
   localparam int RST_DIS = PER_SIDE_DIS ? (DIR_RESET ? DIS_B_CYC : DIS_A_CYC) : DIS_MAX;
   localparam logic [CNT_W-1:0] SETTLE_RST = CNT_W'(RST_DIS + HEADROOM_CYC - 1);

   generate
      if (DIS_A_CYC < 1 || DIS_B_CYC < 1) begin : g_bad_dis
         $error("turn-off waits must be at least one cycle");
      end
      if (EN_A_CYC < 1 || EN_B_CYC < 1) begin : g_bad_en
         $error("turn-on waits must be at least one cycle");
      end
      if (HEADROOM_CYC < 0) begin : g_bad_head
         $error("headroom must not be negative");
      end
   endgenerate

   logic             t_load, t_zero, sel_off;
   logic [CNT_W-1:0] t_val, dis_cyc, en_cyc;

   xds_delay_sel #(
      .W(CNT_W), .DIS_A_CYC(DIS_A_CYC), .DIS_B_CYC(DIS_B_CYC),
      .EN_A_CYC(EN_A_CYC), .EN_B_CYC(EN_B_CYC), .PER_SIDE(PER_SIDE_DIS)
   ) u_sel (
      .off_side(sel_off), .drive_side(xcvr_dir), .dis_cyc(dis_cyc), .en_cyc(en_cyc)
   );

   xds_timer #(.W(CNT_W), .RST_VAL(SETTLE_RST)) u_tmr (
      .clk(clk), .rst_n(rst_n), .load(t_load), .load_val(t_val), .zero(t_zero)
   );

   xds_ctrl #(.W(CNT_W), .HEADROOM_CYC(HEADROOM_CYC), .DIR_RESET(DIR_RESET)) u_ctrl (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_dir(req_dir),
      .t_zero(t_zero), .dis_cyc(dis_cyc), .en_cyc(en_cyc),
      .t_load(t_load), .t_val(t_val), .sel_off(sel_off),
      .xcvr_dir(xcvr_dir), .xcvr_oe_n(xcvr_oe_n),
      .req_ready(req_ready), .xfer_ready(xfer_ready)
   );

   // cycles elapsed with outputs off, saturating; guards the turn-off gap
   logic [CNT_W-1:0] since_off;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                 since_off <= '0;
      else if (!xcvr_oe_n)        since_off <= '0;
      else if (since_off != '1)   since_off <= since_off + CNT_W'(1);
   end

   AST_DIR_ONLY_WHILE_OFF: assert property (@(posedge clk) disable iff (!rst_n)
      (xcvr_dir != $past(xcvr_dir)) |-> (xcvr_oe_n && $past(xcvr_oe_n))); // R4
   AST_OFF_GAP_MET: assert property (@(posedge clk) disable iff (!rst_n)
      (xcvr_dir != $past(xcvr_dir)) |-> (since_off >= dis_cyc)); // R5
   AST_READY_DRIVING: assert property (@(posedge clk) disable iff (!rst_n)
      xfer_ready |-> !xcvr_oe_n); // R7
   AST_SAME_DIR_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_ready && (req_dir == xcvr_dir))
      |=> ($stable(xcvr_dir) && !xcvr_oe_n && req_ready)); // R8
   AST_BUSY_AFTER_SWITCH: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_ready && (req_dir != xcvr_dir)) |=> (!req_ready && xcvr_oe_n)); // R9
endmodule

// File: tb/sim_xcvr_dir_sequencer.sv
module sim_xcvr_dir_sequencer;
   localparam int DA = 3, DB = 5, EA = 4, EB = 2, HD = 2;
   localparam int DMAX = (DA > DB) ? DA : DB;

   logic clk = 1'b0;
   always #4 clk = ~clk;   // 125 MHz

   logic       rst_n = 1'b0;
   logic [1:0] rv = '0, rd = '0;
   wire  [1:0] rr, xr, dv, oen;
   int n_chk = 0, n_fail = 0, cyc = 0;

   always @(posedge clk) cyc <= cyc + 1;

   xcvr_dir_sequencer #(.DIS_A_CYC(DA), .DIS_B_CYC(DB), .EN_A_CYC(EA), .EN_B_CYC(EB),
      .HEADROOM_CYC(HD), .DIR_RESET(1'b1), .PER_SIDE_DIS(1'b0)) u0 (
      .clk(clk), .rst_n(rst_n), .req_valid(rv[0]), .req_dir(rd[0]), .req_ready(rr[0]),
      .xcvr_dir(dv[0]), .xcvr_oe_n(oen[0]), .xfer_ready(xr[0]));

   xcvr_dir_sequencer #(.DIS_A_CYC(DA), .DIS_B_CYC(DB), .EN_A_CYC(EA), .EN_B_CYC(EB),
      .HEADROOM_CYC(HD), .DIR_RESET(1'b0), .PER_SIDE_DIS(1'b1)) u1 (
      .clk(clk), .rst_n(rst_n), .req_valid(rv[1]), .req_dir(rd[1]), .req_ready(rr[1]),
      .xcvr_dir(dv[1]), .xcvr_oe_n(oen[1]), .xfer_ready(xr[1]));

   function automatic bit dir_rst(int g);
      return (g == 0);
   endfunction
   function automatic int exp_dis(int g, bit leaving);
      if (g == 1) return leaving ? DB : DA;   // R10 per-side wait
      return DMAX;
   endfunction
   function automatic int exp_en(bit d);
      return d ? EB : EA;
   endfunction

   task automatic chk(bit ok, string req, int act, int exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%0d expected=%0d (t=%0t)", req, act, exp, $time);
      end
   endtask

   // gap monitors, one per instance
   for (genvar g = 0; g < 2; g++) begin : g_mon
      logic p_oe, p_dir, old_dir, p_xr, p_rst;
      int   t_off, t_dir, t_on;
      always @(negedge clk) begin
         if (!rst_n) begin
            p_oe = 1'b1; p_dir = dir_rst(g); old_dir = dir_rst(g); p_xr = 1'b0; p_rst = 1'b0;
            t_off = 0; t_dir = 0; t_on = 0;
         end else begin
            if (!p_rst) t_dir = cyc - 1;
            if (oen[g] && !p_oe) t_off = cyc;
            if (dv[g] != p_dir) begin
               chk(oen[g] && p_oe, "R4 dir moved with outputs on", {31'd0, p_oe}, 1);
               chk(cyc - t_off == exp_dis(g, p_dir) + 1, (g == 1) ? "R10" : "R5",
                   cyc - t_off, exp_dis(g, p_dir) + 1);
               old_dir = p_dir;
               t_dir = cyc;
            end
            if (!oen[g] && p_oe) begin
               chk(cyc - t_dir == exp_dis(g, old_dir) + HD, (g == 1) ? "R10" : "R6",
                   cyc - t_dir, exp_dis(g, old_dir) + HD);
               t_on = cyc;
            end
            if (xr[g] && !p_xr)
               chk(cyc - t_on == exp_en(dv[g]), "R7 enable wait", cyc - t_on, exp_en(dv[g]));
            p_oe = oen[g]; p_dir = dv[g]; p_xr = xr[g]; p_rst = 1'b1;
         end
      end
   end

   task automatic wait_ready(int g);
      int n = 0;
      while (!xr[g] && n < 500) begin @(negedge clk); n++; end
      chk(xr[g], "R7 ready reached", {31'd0, xr[g]}, 1);
   endtask

   task automatic req(int g, bit d, output int blocked);
      blocked = 0;
      rv[g] = 1'b1; rd[g] = d;
      while (!rr[g] && blocked < 500) begin @(negedge clk); blocked++; end
      @(negedge clk);
      rv[g] = 1'b0;
   endtask

   task automatic run_seq(int g);
      bit cur;
      int blk;
      bit [5:0] pat = 6'b101100;
      cur = dv[g];
      // R8 same direction: accepted, no pin activity
      chk(rr[g], "R8 ready before same-dir", {31'd0, rr[g]}, 1);
      req(g, cur, blk);
      chk(blk == 0, "R8 accepted at once", blk, 0);
      chk(dv[g] == cur && !oen[g] && xr[g], "R8 pins unchanged",
          {29'd0, dv[g], oen[g], xr[g]}, {29'd0, cur, 2'b01});
      repeat (3) @(negedge clk);
      chk(!oen[g] && xr[g] && rr[g], "R8 still ready", {30'd0, oen[g], xr[g]}, 1);
      // R9 switch then a held request back to the original direction
      rv[g] = 1'b1; rd[g] = ~cur;
      @(negedge clk);
      rv[g] = 1'b0;
      chk(!rr[g] && oen[g], "R9 busy after switch", {30'd0, rr[g], oen[g]}, 1);
      req(g, cur, blk);
      chk(blk > 0, "R9 request held off", blk, 1);
      wait_ready(g);
      chk(dv[g] == cur, "R9 held request done", {31'd0, dv[g]}, {31'd0, cur});
      // sweep of direction patterns
      for (int i = 0; i < 6; i++) begin
         req(g, pat[i], blk);
         wait_ready(g);
         chk(dv[g] == pat[i], "R3 direction as requested", {31'd0, dv[g]}, {31'd0, pat[i]});
      end
   endtask

   initial begin
      repeat (3) @(negedge clk);
      for (int g = 0; g < 2; g++) begin
         chk(oen[g] == 1'b1, "R1 oe_n in reset", {31'd0, oen[g]}, 1);
         chk(dv[g] == dir_rst(g), "R1 dir in reset", {31'd0, dv[g]}, {31'd0, dir_rst(g)});
         chk(!rr[g] && !xr[g], "R1 flags low in reset", {30'd0, rr[g], xr[g]}, 0);
      end
      #1 rst_n = 1'b1;
      @(negedge clk);
      chk(!xr[0] && !xr[1] && oen == 2'b11, "R2 not ready right after reset",
          {30'd0, xr}, 0);
      for (int g = 0; g < 2; g++) begin
         wait_ready(g);
         chk(dv[g] == dir_rst(g), "R2 dir kept at default", {31'd0, dv[g]},
             {31'd0, dir_rst(g)});
      end
      for (int g = 0; g < 2; g++) run_seq(g);
      repeat (4) @(negedge clk);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      n_chk++; n_fail++;
      $display("FAIL watchdog expired actual=hung expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end
endmodule